// File: doc/BRIEF.md
# Endpoint DMA Handshake Controller

This block runs the request/acknowledge handshake between an external DMA engine and the endpoint buffers of a USB device controller. Software picks one of fourteen endpoints as the single DMA target through a 4-bit index. The direction comes from that endpoint's direction bit. The block raises a request when the target can move data, and turns each acknowledged cycle into a byte strobe toward the buffer of that endpoint. It ends a transfer for one of three reasons: a software-loaded byte count runs out, an external end-of-transfer pin is asserted, or a short or empty packet arrives. It then holds a sticky completion flag.

The processor's ordinary I/O path to the endpoint buffers goes through the same steering logic. While acknowledge is inactive, processor accesses pass through to whatever endpoint the processor addresses. While acknowledge is active, the DMA target takes the buffer and processor strobes are held off. This lets the two kinds of access interleave cycle by cycle. Two handshake styles are available: a strobed style in which the request drops after each completed burst, and an acknowledge-only style. The active level of each handshake pin can be programmed.

Top module: `ep_dma_handshake`

## Requirements
- R1: After reset the request pin is at its inactive level, the completion flag is 0, the transfer count is 0, and no buffer strobe is active while the processor drives none.
- R2: Index codes 2 to 15 select endpoints 1 to 14, and code c uses bit c-2 of every per-endpoint status vector. Codes 0 and 1 select nothing: they produce no request and no DMA strobe.
- R3: A selected endpoint whose direction bit is 0 (OUT) is read, so each DMA byte pulses `buf_rd`. A direction bit of 1 (IN) means a write, so each DMA byte pulses `buf_wr`. The two strobes are never active together during a DMA byte.
- R4: The request is registered and rises one cycle after all of these hold: DMA is enabled, the completion flag is clear, the count is nonzero, and the target has data (OUT) or space (IN). Disabling DMA drops the request in the next cycle.
- R5: While acknowledge is active, `buf_sel` carries the configured DMA index and processor strobes are blocked. While acknowledge is inactive, `buf_sel`, `buf_rd` and `buf_wr` follow the processor I/O inputs, and the DMA count is unaffected.
- R6: In strobed mode (`cfg_ack_only`=0), a DMA byte needs acknowledge together with `bus_rd` (OUT) or `bus_wr` (IN). After the byte that completes a burst of `cfg_burst` bytes, the request is low for the next cycle. A burst value of 0 means single bytes, and values above 16 act as 16.
- R7: In acknowledge-only mode (`cfg_ack_only`=1), every cycle with acknowledge active moves one byte whatever `bus_rd` and `bus_wr` are doing, and the request stays up across burst boundaries.
- R8: `cnt_load` loads the count, and each DMA byte decrements it. The byte that brings it to zero sets the completion flag in the next cycle and drops the request.
- R9: The end-of-transfer pin at its active level, while acknowledge is active and a transfer is armed, sets the completion flag in the next cycle.
- R10: A read byte taken while the target's `ep_short_last` bit is 1 sets the completion flag. An `ep_zlp` bit of 1 on an armed OUT target sets the flag with no strobe.
- R11: The completion flag stays set until a `done_clr` pulse. A new end condition wins over a clear in the same cycle. While the flag is set, acknowledge produces no DMA strobe.
- R12: The active level of each pin is set by its own bit (1 = active high): `cfg_req_pol` for `dreq`, `cfg_ack_pol` for `dack`, and `cfg_eot_pol` for `eot_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | DMA enable |
| cfg_ep_idx | input | 4 | DMA target index code |
| cfg_burst | input | 5 | Bytes per burst (0 = single) |
| cfg_ack_only | input | 1 | 1 = acknowledge-only style, 0 = strobed style |
| cfg_req_pol | input | 1 | Request active level |
| cfg_ack_pol | input | 1 | Acknowledge active level |
| cfg_eot_pol | input | 1 | End-of-transfer pin active level |
| cnt_load | input | 1 | Load transfer count |
| cnt_value | input | 16 | Count to load |
| done_clr | input | 1 | Write-one clear of the completion flag |
| ep_dir | input | 14 | Per-endpoint direction (1 = IN) |
| ep_data | input | 14 | Per-endpoint buffer holds data |
| ep_space | input | 14 | Per-endpoint buffer has space |
| ep_short_last | input | 14 | Next byte is the last of a short packet |
| ep_zlp | input | 14 | Buffer holds a zero-length packet |
| io_ep_idx | input | 4 | Processor I/O endpoint index |
| io_rd | input | 1 | Processor buffer read |
| io_wr | input | 1 | Processor buffer write |
| bus_rd | input | 1 | DMA read strobe (strobed style) |
| bus_wr | input | 1 | DMA write strobe (strobed style) |
| dack | input | 1 | DMA acknowledge pin |
| eot_pin | input | 1 | External end-of-transfer pin |
| dreq | output | 1 | DMA request pin |
| buf_sel | output | 4 | Endpoint index steered to the buffers |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| dma_count | output | 16 | Remaining transfer count |
| done | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach from the ports is an end condition and a flag clear arriving in the same cycle. The zero-length-packet end can only fire once the flag has been cleared, so the collision has to be set up one cycle ahead. The stimulus raises `ep_zlp` on an OUT target that is already finished and holds `done_clr` for two cycles. The first cycle clears the flag. In the second, the pending empty packet sets it again while the clear is still asserted. The bench also holds acknowledge and the read strobe across the byte that empties the count, which shows that a late acknowledge after completion produces no strobe.

// File: rtl/ep_dma_handshake.sv
module ep_dma_handshake #(
  parameter int NUM_EP    = 14,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 16,
  parameter int BURST_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dma_en,
  input  logic [IDX_W-1:0]  cfg_ep_idx,
  input  logic [$clog2(BURST_MAX+1)-1:0] cfg_burst,
  input  logic              cfg_ack_only,
  input  logic              cfg_req_pol,
  input  logic              cfg_ack_pol,
  input  logic              cfg_eot_pol,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              done_clr,
  input  logic [NUM_EP-1:0] ep_dir,
  input  logic [NUM_EP-1:0] ep_data,
  input  logic [NUM_EP-1:0] ep_space,
  input  logic [NUM_EP-1:0] ep_short_last,
  input  logic [NUM_EP-1:0] ep_zlp,
  input  logic [IDX_W-1:0]  io_ep_idx,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              dack,
  input  logic              eot_pin,
  output logic              dreq,
  output logic [IDX_W-1:0]  buf_sel,
  output logic              buf_rd,
  output logic              buf_wr,
  output logic [CNT_W-1:0]  dma_count,
  output logic              done
);
  localparam int BW       = $clog2(BURST_MAX + 1);
  localparam int IDX_BASE = 2;

  logic             req_q, done_q;
  logic [BW-1:0]    beat_q;
  logic [CNT_W-1:0] cnt_q;

  // target decode: code c -> status bit c-IDX_BASE
  logic [IDX_W-1:0] ep_k;
  logic sel_ok, sel_dir, sel_avail;
  assign ep_k      = cfg_ep_idx - IDX_W'(IDX_BASE);
  assign sel_ok    = (cfg_ep_idx >= IDX_W'(IDX_BASE)) &&
                     ({1'b0, ep_k} < (IDX_W+1)'(NUM_EP));
  assign sel_dir   = sel_ok & ep_dir[ep_k];
  assign sel_avail = sel_ok & (sel_dir ? ep_space[ep_k] : ep_data[ep_k]);

  logic ack_act, eot_act, armed, qual, dma_byte;
  assign ack_act  = (dack == cfg_ack_pol);
  assign eot_act  = (eot_pin == cfg_eot_pol);
  assign armed    = cfg_dma_en & sel_ok & ~done_q & (|cnt_q);
  assign qual     = cfg_ack_only | (sel_dir ? bus_wr : bus_rd);
  assign dma_byte = ack_act & armed & sel_avail & qual;

  logic [BW-1:0] blen;
  assign blen = (cfg_burst == '0) ? BW'(1) :
                (cfg_burst > BW'(BURST_MAX)) ? BW'(BURST_MAX) : cfg_burst;

  logic burst_end, cnt_end, short_end, zlp_end, pin_end, xfer_end;
  assign burst_end = dma_byte & ((beat_q + BW'(1)) == blen);
  assign cnt_end   = dma_byte & (cnt_q == CNT_W'(1));
  assign short_end = dma_byte & ~sel_dir & ep_short_last[ep_k];
  assign zlp_end   = armed & ~sel_dir & ep_zlp[ep_k];
  assign pin_end   = armed & ack_act & eot_act;
  assign xfer_end  = cnt_end | short_end | zlp_end | pin_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      beat_q <= '0;
      cnt_q  <= '0;
    end else begin
      req_q <= armed & sel_avail & ~xfer_end & ~(burst_end & ~cfg_ack_only);
      if (xfer_end)     done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (!armed || burst_end || xfer_end) beat_q <= '0;
      else if (dma_byte)                   beat_q <= beat_q + BW'(1);
      if (cnt_load)      cnt_q <= cnt_value;
      else if (dma_byte) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign dreq      = cfg_req_pol ? req_q : ~req_q;
  assign buf_sel   = ack_act ? cfg_ep_idx : io_ep_idx;
  assign buf_rd    = ack_act ? (dma_byte & ~sel_dir) : io_rd;
  assign buf_wr    = ack_act ? (dma_byte & sel_dir) : io_wr;
  assign dma_count = cnt_q;
  assign done      = done_q;

  assert_rdwr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_act |-> !(buf_rd && buf_wr));
  assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |=> !req_q);
  assert_burst_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !cfg_ack_only) |=> !req_q);
  assert_count_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_byte && dma_count == CNT_W'(1) && !cnt_load) |=> (done_q && dma_count == '0));
  assert_pin_eot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ack_act && eot_act) |=> done_q);
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q);
  assert_done_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ack_act) |-> !(buf_rd || buf_wr));
endmodule

// File: tb/tb_ep_dma_handshake.sv
module tb_ep_dma_handshake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_dma_en, cfg_ack_only, cfg_req_pol, cfg_ack_pol, cfg_eot_pol;
  logic [3:0] cfg_ep_idx, io_ep_idx;
  logic [4:0] cfg_burst;
  logic cnt_load, done_clr;
  logic [15:0] cnt_value;
  logic [13:0] ep_dir, ep_data, ep_space, ep_short_last, ep_zlp;
  logic io_rd, io_wr, bus_rd, bus_wr, dack, eot_pin;
  logic dreq, buf_rd, buf_wr, done;
  logic [3:0] buf_sel;
  logic [15:0] dma_count;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  logic [5:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_dma_handshake dut (
    .clk, .rst_n, .cfg_dma_en, .cfg_ep_idx, .cfg_burst, .cfg_ack_only,
    .cfg_req_pol, .cfg_ack_pol, .cfg_eot_pol, .cnt_load, .cnt_value, .done_clr,
    .ep_dir, .ep_data, .ep_space, .ep_short_last, .ep_zlp,
    .io_ep_idx, .io_rd, .io_wr, .bus_rd, .bus_wr, .dack, .eot_pin,
    .dreq, .buf_sel, .buf_rd, .buf_wr, .dma_count, .done
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask
  task automatic sample; @(negedge clk); endtask
  task automatic set_ack(input logic a); dack = cfg_ack_pol ? a : ~a; endtask
  task automatic push(input logic [3:0] idx, input logic rd, input logic wr);
    exp_q.push_back({idx, rd, wr});
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: every buffer strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && (buf_rd || buf_wr)) begin
      if (exp_q.size() == 0) chk(0, "R3/R5 unexpected strobe", {buf_sel, buf_rd, buf_wr}, 0);
      else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        chk({buf_sel, buf_rd, buf_wr} == e, "R3/R5 strobe", {buf_sel, buf_rd, buf_wr}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_dma_en = 0; cfg_ack_only = 0; cfg_req_pol = 1; cfg_ack_pol = 1;
    cfg_eot_pol = 0; cfg_ep_idx = 0; cfg_burst = 0; cnt_load = 0; cnt_value = 0;
    done_clr = 0; ep_dir = 0; ep_data = 0; ep_space = 0; ep_short_last = 0; ep_zlp = 0;
    io_ep_idx = 0; io_rd = 0; io_wr = 0; bus_rd = 0; bus_wr = 0; dack = 0; eot_pin = 1;
    repeat (3) @(posedge clk);
    sample();
    chk(dreq == 0, "R1 dreq", dreq, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(dma_count == 0, "R1 count", dma_count, 0);
    chk((buf_rd | buf_wr) == 0, "R1 strobes", buf_rd | buf_wr, 0);
    tick(); rst_n = 1;

    // strobed mode, OUT endpoint 2 (code 3), burst 2
    cfg_dma_en = 1; cfg_ep_idx = 4'b0011; cfg_burst = 2; cnt_value = 5; cnt_load = 1;
    ep_data = 14'b1;
    tick(); cnt_load = 0;
    sample();
    chk(dma_count == 5, "R8 load", dma_count, 5);
    chk(dreq == 0, "R2 data on other endpoint", dreq, 0);
    tick(); ep_data = 14'b10;
    sample(); chk(dreq == 0, "R4 registered request", dreq, 0);
    tick(); sample(); chk(dreq == 1, "R4 request", dreq, 1);

    tick(); set_ack(1); bus_rd = 1; io_ep_idx = 5; io_wr = 1; push(4'd3, 1, 0);
    sample();
    chk(buf_sel == 3, "R5 ack steering", buf_sel, 3);
    chk(buf_wr == 0, "R5 io blocked", buf_wr, 0);
    tick(); push(4'd3, 1, 0);
    sample(); chk(dma_count == 4, "R8 decrement", dma_count, 4);
    tick(); set_ack(0); bus_rd = 0; io_wr = 0;
    sample();
    chk(dreq == 0, "R6 burst gap", dreq, 0);
    chk(dma_count == 3, "R8 decrement", dma_count, 3);
    tick(); sample(); chk(dreq == 1, "R6 re-request", dreq, 1);

    tick(); set_ack(1);
    sample(); chk(buf_rd == 0, "R6 needs bus_rd", buf_rd, 0);
    tick(); set_ack(0); io_ep_idx = 7; io_rd = 1; push(4'd7, 1, 0);
    sample();
    chk(dma_count == 3, "R6 no byte without strobe", dma_count, 3);
    chk(buf_sel == 7, "R5 io path", buf_sel, 7);
    tick(); io_rd = 0;
    sample(); chk(dma_count == 3, "R5 io leaves count", dma_count, 3);

    tick(); set_ack(1); bus_rd = 1; push(4'd3, 1, 0);
    tick(); push(4'd3, 1, 0);
    tick(); push(4'd3, 1, 0);
    tick();
    sample();
    chk(done == 1, "R8 done at zero", done, 1);
    chk(dma_count == 0, "R8 zero", dma_count, 0);
    chk(buf_rd == 0, "R11 strobe suppressed", buf_rd, 0);
    chk(dreq == 0, "R8 request dropped", dreq, 0);
    tick(); set_ack(0); bus_rd = 0;
    tick(); tick();
    sample(); chk(done == 1, "R11 sticky", done, 1);
    tick(); done_clr = 1;
    tick(); done_clr = 0;
    sample(); chk(done == 0, "R11 clear", done, 0);
    tick(); sample(); chk(dreq == 0, "R4 zero count", dreq, 0);

    // acknowledge-only mode, IN endpoint 14 (code 15)
    cfg_ack_only = 1; cfg_ep_idx = 4'b1111; ep_dir = 14'h2000; ep_space = 14'h2000;
    cnt_value = 10; cnt_load = 1;
    tick(); cnt_load = 0;
    tick(); sample(); chk(dreq == 1, "R4 IN request", dreq, 1);
    tick(); set_ack(1); push(4'd15, 0, 1);
    tick(); push(4'd15, 0, 1);
    tick(); push(4'd15, 0, 1);
    sample(); chk(dreq == 1, "R7 no burst gap", dreq, 1);
    tick(); set_ack(0); bus_wr = 1;
    sample();
    chk(dma_count == 7, "R7 bytes counted", dma_count, 7);
    chk(buf_wr == 0, "R7 bus strobe ignored", buf_wr, 0);
    tick(); bus_wr = 0;

    // inverted polarities and pin end
    cfg_req_pol = 0; cfg_ack_pol = 0; dack = 1;
    sample(); chk(dreq == 0, "R12 active-low request", dreq, 0);
    tick(); set_ack(1); eot_pin = 0; push(4'd15, 0, 1);
    sample(); chk(buf_wr == 1, "R12 active-low ack", buf_wr, 1);
    tick(); set_ack(0); eot_pin = 1;
    sample();
    chk(done == 1, "R9 pin end", done, 1);
    chk(dreq == 1, "R12 inactive high", dreq, 1);
    chk(dma_count == 6, "R9 count", dma_count, 6);
    tick(); cfg_req_pol = 1; cfg_ack_pol = 1; dack = 0; done_clr = 1;
    tick(); done_clr = 0;

    // single-byte strobed mode, OUT endpoint 1 (code 2), short packet
    cfg_ack_only = 0; cfg_ep_idx = 4'b0010; ep_dir = 0; ep_data = 14'b1; ep_space = 0;
    cfg_burst = 0; cnt_value = 10; cnt_load = 1;
    tick(); cnt_load = 0;
    tick(); sample(); chk(dreq == 1, "R4 request", dreq, 1);
    tick(); set_ack(1); bus_rd = 1; push(4'd2, 1, 0);
    tick(); set_ack(0); bus_rd = 0;
    sample(); chk(dreq == 0, "R6 single gap", dreq, 0);
    tick(); ep_short_last = 14'b1; set_ack(1); bus_rd = 1; push(4'd2, 1, 0);
    tick(); set_ack(0); bus_rd = 0; ep_short_last = 0;
    sample();
    chk(done == 1, "R10 short packet", done, 1);
    chk(dma_count == 8, "R10 count", dma_count, 8);
    tick(); ep_zlp = 14'b1; done_clr = 1;
    tick();
    sample(); chk(done == 0, "R11 clear", done, 0);
    tick(); done_clr = 0;
    sample();
    chk(done == 1, "R10 empty packet / R11 set wins", done, 1);
    chk(dma_count == 8, "R10 no strobe", dma_count, 8);
    ep_zlp = 0;

    // invalid code
    tick(); done_clr = 1;
    tick(); done_clr = 0; cfg_ep_idx = 4'b0001; ep_data = '1;
    tick(); tick();
    sample(); chk(dreq == 0, "R2 invalid code", dreq, 0);
    tick(); set_ack(1); bus_rd = 1;
    sample(); chk(buf_rd == 0, "R2 no strobe", buf_rd, 0);
    tick(); set_ack(0); bus_rd = 0;
    sample(); chk(dma_count == 8, "R2 count", dma_count, 8);

    // disable
    cfg_ep_idx = 4'b0010;
    tick(); tick();
    sample(); chk(dreq == 1, "R4 request", dreq, 1);
    tick(); cfg_dma_en = 0;
    tick(); sample(); chk(dreq == 0, "R4 disable", dreq, 0);

    tick();
    chk(exp_q.size() == 0, "R3/R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule